// File: doc/BRIEF.md
# Key-Guarded Flash Control Register

This block is the command register that sits in front of a nonvolatile memory operation engine. Software selects an operation by writing fields into a control word. The fields are programming enable, sector erase, whole-bank erase, a 2-bit access width, a force-write flag, a start strobe and a sector index. The block then drives those fields straight to the engine. The memory array itself, its timing and any option storage sit outside this block.

The control word comes out of reset locked. To open it, software writes two fixed 32-bit keys, one after the other, into a separate key register. Writing the control word with its lowest bit set closes it again at once. Any misuse of the key register freezes unlocking until the next reset and raises a sticky fault output. Misuse means a wrong value, the two keys in the wrong order, or a key write while the register is already open. The start strobe is not stored. It reaches the engine as a one-cycle pulse.

Top module: `nvm_ctl_guard`

## Requirements
- R1: After reset the control word reads 0x00000001 (lock bit 0 set, every field 0), the fault output is 0 and every engine output is 0.
- R2: Writing KEY_A (default 0x45670123) and then KEY_B (default 0xCDEF89AB) to the key register at offset 0x04 clears lock bit 0 of the control word at offset 0x0C. Only this sequence clears it.
- R3: A first key write whose value differs from KEY_A sets the fault output and leaves the word locked.
- R4: A second key write whose value differs from KEY_B sets the fault output and leaves the word locked. This covers KEY_B followed by KEY_A, and KEY_A written twice.
- R5: A key write while the word is unlocked sets the fault output. The word stays unlocked and its fields are unchanged.
- R6: The fault output stays set until reset. While it is set, even a correct key sequence does not unlock the word.
- R7: While locked, every control write is discarded. Readback and engine outputs keep their values.
- R8: An unlocked control write with bit 0 clear loads the fields: program enable bit 1, sector erase bit 2, bank erase bit 3, width bits 5:4 (0=8, 1=16, 2=32, 3=64 bit), force write bit 6, and sector index bits 8 upward, SECT_W bits wide. Higher bits are dropped.
- R9: An unlocked control write with bit 0 set locks the word at once and leaves every field unchanged.
- R10: An unlocked control write with bit 7 set makes op_start high for exactly the next cycle. Bit 7 always reads back as 0.
- R11: Reads are combinational. Offset 0x0C returns the current control word, and any other offset, including the key register, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| key_fault | output | 1 | Sticky key-misuse flag |
| op_prog | output | 1 | Programming enable to engine |
| op_sect_erase | output | 1 | Sector erase request |
| op_bank_erase | output | 1 | Bank erase request |
| op_width | output | 2 | Access width code |
| op_force | output | 1 | Force-write of a partial buffer |
| op_start | output | 1 | One-cycle start pulse |
| op_sector | output | SECT_W | Sector index |

## Verification
The bench builds the block with SECT_W set to 4 and the default keys. A sector write can then carry a fifth index bit at position 12, and the bench checks that this bit is dropped. With the default keys, one wrong value is enough to test both the first-key and the second-key mismatch paths. The vector table runs a long chain of lock, unlock, relock and fault steps without any reset between them. The final steps show that a correct key pair no longer opens the register once the fault is set.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;

  localparam int BIT_LOCK   = 0;
  localparam int BIT_PROG   = 1;
  localparam int BIT_SERASE = 2;
  localparam int BIT_BERASE = 3;
  localparam int WID_LSB    = 4;
  localparam int BIT_FORCE  = 6;
  localparam int BIT_START  = 7;
  localparam int SECT_LSB   = 8;

  typedef enum logic [1:0] {
    KS_SHUT = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2
  } key_state_e;

  typedef struct packed {
    logic       prog;
    logic       sect_erase;
    logic       bank_erase;
    logic [1:0] width;
    logic       force_wr;
  } ctl_fields_t;

  function automatic ctl_fields_t fields_from_word(input logic [6:1] w);
    ctl_fields_t f;
    f.prog       = w[BIT_PROG];
    f.sect_erase = w[BIT_SERASE];
    f.bank_erase = w[BIT_BERASE];
    f.width      = w[WID_LSB+1:WID_LSB];
    f.force_wr   = w[BIT_FORCE];
    return f;
  endfunction

  function automatic logic [31:0] ctl_image(input ctl_fields_t f,
                                            input logic [23:0] sec,
                                            input logic lk);
    logic [31:0] w;
    w = '0;
    w[BIT_LOCK]              = lk;
    w[BIT_PROG]              = f.prog;
    w[BIT_SERASE]            = f.sect_erase;
    w[BIT_BERASE]            = f.bank_erase;
    w[WID_LSB+1:WID_LSB]     = f.width;
    w[BIT_FORCE]             = f.force_wr;
    w[SECT_LSB+23:SECT_LSB]  = sec;
    return w;
  endfunction

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_guard_pkg::*;
#(
  parameter logic [31:0] KEY_A = 32'h4567_0123,
  parameter logic [31:0] KEY_B = 32'hCDEF_89AB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        locked,
  output logic        fault
);

  key_state_e state_q, state_d;
  logic       fault_q, fault_d;
  logic       key_bad_evt;
  logic       unlock_evt;

  always_comb begin
    state_d     = state_q;
    fault_d     = fault_q;
    key_bad_evt = 1'b0;
    unlock_evt  = 1'b0;
    if (key_wr && !fault_q) begin
      unique case (state_q)
        KS_SHUT: begin
          if (key_data == KEY_A) state_d = KS_HALF;
          else key_bad_evt = 1'b1;
        end
        KS_HALF: begin
          if (key_data == KEY_B) begin
            state_d    = KS_OPEN;
            unlock_evt = 1'b1;
          end else begin
            state_d     = KS_SHUT;
            key_bad_evt = 1'b1;
          end
        end
        default: key_bad_evt = 1'b1;
      endcase
    end else if (relock && state_q == KS_OPEN) begin
      state_d = KS_SHUT;
    end
    if (key_bad_evt) fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_SHUT;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  assign locked = (state_q != KS_OPEN);
  assign fault  = fault_q;

  p_unlock_keyed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(key_wr && key_data == KEY_B))
    else $error("unlock without second key");

  p_open_key_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !locked) |=> fault)
    else $error("key write while open did not fault");

  p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault)
    else $error("fault cleared");

  p_frozen_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && locked) |=> locked)
    else $error("unlock after fault");

endmodule

// File: rtl/nvm_ctl_fields.sv
module nvm_ctl_fields
  import nvm_guard_pkg::*;
#(
  parameter int SECT_W = 3,
  localparam int CTL_W = SECT_LSB + SECT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CTL_W-1:1]   wbits,
  output ctl_fields_t        fields,
  output logic [SECT_W-1:0]  sector,
  output logic               start_pulse
);

  ctl_fields_t        fields_q;
  logic [SECT_W-1:0]  sector_q;
  logic               start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      sector_q <= '0;
      start_q  <= 1'b0;
    end else begin
      start_q <= wr_en && wbits[BIT_START];
      if (wr_en) begin
        fields_q <= fields_from_word(wbits[6:1]);
        sector_q <= wbits[SECT_LSB +: SECT_W];
      end
    end
  end

  assign fields      = fields_q;
  assign sector      = sector_q;
  assign start_pulse = start_q;

endmodule

// File: rtl/nvm_ctl_guard.sv
module nvm_ctl_guard
  import nvm_guard_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          SECT_W  = 3,
  parameter logic [31:0] KEY_A   = 32'h4567_0123,
  parameter logic [31:0] KEY_B   = 32'hCDEF_89AB,
  parameter int          KEY_OFS = 4,
  parameter int          CTL_OFS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              key_fault,
  output logic              op_prog,
  output logic              op_sect_erase,
  output logic              op_bank_erase,
  output logic [1:0]        op_width,
  output logic              op_force,
  output logic              op_start,
  output logic [SECT_W-1:0] op_sector
);

  localparam int CTL_W = SECT_LSB + SECT_W;
  localparam logic [ADDR_W-1:0] KEY_ADR = ADDR_W'(KEY_OFS);
  localparam logic [ADDR_W-1:0] CTL_ADR = ADDR_W'(CTL_OFS);

  logic        key_hit, ctl_hit;
  logic        locked;
  logic        field_wr;
  logic        relock_req;
  ctl_fields_t fields;

  assign key_hit    = bus_we && (bus_addr == KEY_ADR);
  assign ctl_hit    = bus_we && (bus_addr == CTL_ADR);
  assign field_wr   = ctl_hit && !locked && !bus_wdata[BIT_LOCK];
  assign relock_req = ctl_hit && !locked &&  bus_wdata[BIT_LOCK];

  nvm_key_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_hit),
    .key_data (bus_wdata),
    .relock   (relock_req),
    .locked   (locked),
    .fault    (key_fault)
  );

  nvm_ctl_fields #(.SECT_W(SECT_W)) u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (field_wr),
    .wbits       (bus_wdata[CTL_W-1:1]),
    .fields      (fields),
    .sector      (op_sector),
    .start_pulse (op_start)
  );

  assign op_prog       = fields.prog;
  assign op_sect_erase = fields.sect_erase;
  assign op_bank_erase = fields.bank_erase;
  assign op_width      = fields.width;
  assign op_force      = fields.force_wr;

  assign bus_rdata = (bus_addr == CTL_ADR) ?
                     ctl_image(fields, 24'(op_sector), locked) : 32'h0;

  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({fields, op_sector}))
    else $error("fields changed while locked");

  p_relock_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    relock_req |=> (locked && $stable({fields, op_sector})))
    else $error("relock write altered fields");

  p_start_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(!locked && ctl_hit))
    else $error("start pulse without unlocked write");

endmodule

// File: tb/nvm_ctl_guard_tb_top.sv
module nvm_ctl_guard_tb_top;

  localparam int SW = 4;
  localparam logic [31:0] KA = 32'h4567_0123;
  localparam logic [31:0] KB = 32'hCDEF_89AB;
  localparam logic [7:0] AK = 8'h04;
  localparam logic [7:0] AC = 8'h0C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = AC;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          key_fault, op_prog, op_sect_erase, op_bank_erase, op_force, op_start;
  logic [1:0]    op_width;
  logic [SW-1:0] op_sector;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nvm_ctl_guard #(.SECT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_fault(key_fault),
    .op_prog(op_prog), .op_sect_erase(op_sect_erase), .op_bank_erase(op_bank_erase),
    .op_width(op_width), .op_force(op_force), .op_start(op_start), .op_sector(op_sector)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp_word;
    logic        exp_fault;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{AC, 32'h0000_0336, 32'h0000_0001, 1'b0},  // R7 locked write dropped
    '{AK, KA,            32'h0000_0001, 1'b0},  // R2 first key
    '{AK, KB,            32'h0000_0000, 1'b0},  // R2 open
    '{AC, 32'h0000_0536, 32'h0000_0536, 1'b0},  // R8
    '{AC, 32'h0000_1F48, 32'h0000_0F48, 1'b0},  // R8 sector bit 12 dropped
    '{AC, 32'h0000_0001, 32'h0000_0F49, 1'b0},  // R9 relock
    '{AC, 32'h0000_0000, 32'h0000_0F49, 1'b0},  // R7
    '{AK, KA,            32'h0000_0F49, 1'b0},  // R2
    '{AK, KB,            32'h0000_0F48, 1'b0},  // R2
    '{AK, KA,            32'h0000_0F48, 1'b1},  // R5 key while open
    '{AC, 32'h0000_0022, 32'h0000_0022, 1'b1},  // R5 still open
    '{AC, 32'h0000_0001, 32'h0000_0023, 1'b1},  // R9
    '{AK, KA,            32'h0000_0023, 1'b1},  // R6
    '{AK, KB,            32'h0000_0023, 1'b1}   // R6 stays locked
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_we = 1'b0; bus_addr = AC;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = AC;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 word", bus_rdata, 32'h1);
    check("R1 fault", 32'(key_fault), 32'h0);
    check("R1 outs", 32'({op_prog, op_sect_erase, op_bank_erase, op_width, op_force, op_start, op_sector}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].data);
      check($sformatf("vec%0d word", i), bus_rdata, VECS[i].exp_word);
      check($sformatf("vec%0d fault", i), 32'(key_fault), 32'(VECS[i].exp_fault));
    end

    // R3 wrong first key
    do_reset();
    wr(AK, 32'h1234_5678);
    check("R3 fault", 32'(key_fault), 32'h1);
    check("R3 locked", bus_rdata, 32'h1);

    // R4 reversed order
    do_reset();
    wr(AK, KB); wr(AK, KA);
    check("R4 reversed fault", 32'(key_fault), 32'h1);
    check("R4 reversed locked", bus_rdata, 32'h1);

    // R4 first key twice
    do_reset();
    wr(AK, KA); wr(AK, KA);
    check("R4 repeat fault", 32'(key_fault), 32'h1);
    wr(AK, KB);
    check("R4 repeat locked", bus_rdata, 32'h1);

    // R10 start pulse and R8 engine outputs
    do_reset();
    wr(AK, KA); wr(AK, KB);
    wr(AC, 32'h0000_03A2);
    check("R10 pulse high", 32'(op_start), 32'h1);
    check("R10 readback", bus_rdata, 32'h0000_0322);
    check("R8 prog", 32'(op_prog), 32'h1);
    check("R8 width", 32'(op_width), 32'h2);
    check("R8 sector", 32'(op_sector), 32'h3);
    check("R8 erase off", 32'({op_sect_erase, op_bank_erase, op_force}), 32'h0);
    @(posedge clk); #1;
    check("R10 pulse low", 32'(op_start), 32'h0);

    // R7 locked start write gives no pulse
    wr(AC, 32'h1);
    wr(AC, 32'h0000_0080);
    check("R7 no pulse", 32'(op_start), 32'h0);
    check("R7 hold", bus_rdata, 32'h0000_0323);

    // R11 other offsets
    @(negedge clk); bus_addr = AK; #1;
    check("R11 key read", bus_rdata, 32'h0);
    bus_addr = 8'h20; #1;
    check("R11 other read", bus_rdata, 32'h0);
    bus_addr = AC; #1;
    check("R11 ctl read", bus_rdata, 32'h0000_0323);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule